// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a register-programmed SPI flash master. Software loads an opcode, an optional address of up to three bytes, a dummy clock count, a chip select choice, a transfer direction and a byte count, then requests a start. The block runs the whole flash transaction on its own in a fixed phase order: opcode, address, dummy clocks, data. The data phase moves up to 64 bytes. The bytes either come out of a local buffer and go to the flash, or come in from the flash and land in that buffer. Each transaction uses only one of these two directions.

The serial side is single-bit SPI mode 0. SCLK idles low and runs at half the system clock. Every byte goes most significant bit first. Software watches a busy flag to learn when the transaction is over. Register writes are byte wide over a simple write strobe, and reads are combinational. After reset the block sits in automatic mode, and a start is refused in that mode. An unlock sequence on the opcode register has to come before software can switch to manual mode.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, busy is 0, both chip selects are high, SCLK and MOSI are low, the control byte (offset 0x04) reads 0x30 and the byte count (offset 0x06) reads 0.
- R2: Control bits 5:4 (reset 2'b11) can only be cleared after writes of 0x55 and then 0xAA as consecutive writes to the opcode register (offset 0x05). Writing 2'b11 to them always succeeds and cancels the unlock. A start (control bit 0) is only accepted while bits 5:4 are 2'b00. In any other case the start is ignored and no transaction begins.
- R3: A start that is accepted raises busy (control bit 1). Busy stays high for exactly 2N+2 system clocks, where N is the total SCLK count of the transaction. Control bit 0 reads back as 0.
- R4: On MOSI, the 8-bit opcode goes out first, MSB first. MOSI changes only while SCLK is low, and each bit is presented for one full SCLK period of two system clocks.
- R5: Configuration byte 0x02 bits 2:0 hold the address size (0 to 3 bytes). The address word sits at 0x08 (bits 7:0), 0x09 and 0x0A. The address goes out MSB first, and the number of bytes sent equals the address size. A size of 0 skips the address phase.
- R6: Configuration byte 0x02 bits 7:3 hold a dummy count D of 0 to 31. D SCLK periods follow the address phase with MOSI held low.
- R7: Control bit 3 sets the direction. When it is 1, buffer bytes (offset 0x40 upward) go out from index 0. When it is 0, MISO is sampled on each rising SCLK edge, MOSI stays low, and the bytes are stored at buffer index 0 upward.
- R8: The byte count can be 0 to 64, and a write above 64 is stored as 64. A count of 0 means there is no data phase.
- R9: Bit 0 of configuration byte 0x03 selects chip select 0 or 1. Only the selected chip select goes low. It falls one system clock before the first SCLK rise and stays the same for the whole transaction. It rises after the last bit and stays high for at least one SCLK period before busy clears.
- R10: While busy is high, all register and buffer writes are ignored.
- R11: The hardware never changes the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Several properties are checked on every cycle:
- at most one chip select is low;
- every SCLK rise follows a chip select that was already low;
- SCLK and MOSI stay quiet while no chip select is active;
- the selected line holds for the whole transaction;
- the chip-select gap before busy falls;
- a start refused in automatic mode.

Other behaviour only the bench scenarios can show:
- the serial bit content;
- the 2N+2 busy length;
- read data landing in the buffer;
- the unlock sequence;
- the count clamp;
- writes made during a transaction being dropped.

To show these, the bench runs a flash model that records MOSI and returns MISO bytes.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    UNL_NONE,
    UNL_SAW55,
    UNL_OPEN
  } unlock_t;

  typedef struct packed {
    logic [2:0]  asz;
    logic [4:0]  dummy;
    logic        cs_sel;
    logic [7:0]  opcode;
    logic        dir;
    logic [23:0] addr;
  } xfer_cfg_t;

  localparam logic [5:0] OFF_CFG2 = 6'h02;
  localparam logic [5:0] OFF_CFG3 = 6'h03;
  localparam logic [5:0] OFF_CTRL = 6'h04;
  localparam logic [5:0] OFF_CMD  = 6'h05;
  localparam logic [5:0] OFF_CNT  = 6'h06;
  localparam logic [5:0] OFF_AD0  = 6'h08;
  localparam logic [5:0] OFF_AD1  = 6'h09;
  localparam logic [5:0] OFF_AD2  = 6'h0A;

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [6:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             busy,
  output logic             start,
  output logic             manual,
  output xfer_cfg_t        cfg,
  output logic [CNT_W-1:0] count,
  input  logic [IDX_W-1:0] buf_ridx,
  output logic [7:0]       buf_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata
);

  logic [2:0]       asz_q, asz_d;
  logic [4:0]       dmy_q, dmy_d;
  logic             sel_q, sel_d;
  logic [7:0]       op_q, op_d;
  logic             dir_q, dir_d;
  logic [1:0]       mode_q, mode_d;
  unlock_t          unl_q, unl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [23:0]      adr_q, adr_d;

  logic [7:0]       mem [BUF_BYTES];
  logic             mem_we;
  logic [IDX_W-1:0] mem_widx;
  logic [7:0]       mem_wdata;
  logic             wr_ok;

  assign wr_ok = we & ~busy;

  always_comb begin
    asz_d  = asz_q;
    dmy_d  = dmy_q;
    sel_d  = sel_q;
    op_d   = op_q;
    dir_d  = dir_q;
    mode_d = mode_q;
    unl_d  = unl_q;
    cnt_d  = cnt_q;
    adr_d  = adr_q;
    start  = 1'b0;
    if (wr_ok && !addr[6]) begin
      unique case (addr[5:0])
        OFF_CFG2: {dmy_d, asz_d} = wdata;
        OFF_CFG3: sel_d = wdata[0];
        OFF_CTRL: begin
          dir_d = wdata[3];
          if (wdata[5:4] == 2'b11) begin
            mode_d = 2'b11;
            unl_d  = UNL_NONE;
          end else if (unl_q == UNL_OPEN) begin
            mode_d = wdata[5:4];
          end
          start = wdata[0] & (mode_q == 2'b00);
        end
        OFF_CMD: begin
          op_d = wdata;
          unique case (unl_q)
            UNL_NONE:  unl_d = (wdata == 8'h55) ? UNL_SAW55 : UNL_NONE;
            UNL_SAW55: unl_d = (wdata == 8'hAA) ? UNL_OPEN :
                               ((wdata == 8'h55) ? UNL_SAW55 : UNL_NONE);
            default:   unl_d = UNL_OPEN;
          endcase
        end
        OFF_CNT:  cnt_d = (wdata > 8'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : CNT_W'(wdata);
        OFF_AD0:  adr_d[7:0]   = wdata;
        OFF_AD1:  adr_d[15:8]  = wdata;
        OFF_AD2:  adr_d[23:16] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asz_q  <= '0;
      dmy_q  <= '0;
      sel_q  <= 1'b0;
      op_q   <= '0;
      dir_q  <= 1'b0;
      mode_q <= 2'b11;
      unl_q  <= UNL_NONE;
      cnt_q  <= '0;
      adr_q  <= '0;
    end else begin
      asz_q  <= asz_d;
      dmy_q  <= dmy_d;
      sel_q  <= sel_d;
      op_q   <= op_d;
      dir_q  <= dir_d;
      mode_q <= mode_d;
      unl_q  <= unl_d;
      cnt_q  <= cnt_d;
      adr_q  <= adr_d;
    end
  end

  // Buffer port: the bus writes when idle, the engine writes while busy.
  always_comb begin
    mem_we    = (wr_ok & addr[6]) | eng_we;
    mem_widx  = eng_we ? eng_widx : addr[IDX_W-1:0];
    mem_wdata = eng_we ? eng_wdata : wdata;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_widx] <= mem_wdata;
  end

  assign buf_rdata = mem[buf_ridx];

  always_comb begin
    rdata = 8'h00;
    if (addr[6]) begin
      rdata = mem[addr[IDX_W-1:0]];
    end else begin
      unique case (addr[5:0])
        OFF_CFG2: rdata = {dmy_q, asz_q};
        OFF_CFG3: rdata = {7'b0, sel_q};
        OFF_CTRL: rdata = {2'b00, mode_q, dir_q, 1'b0, busy, 1'b0};
        OFF_CMD:  rdata = op_q;
        OFF_CNT:  rdata = 8'(cnt_q);
        OFF_AD0:  rdata = adr_q[7:0];
        OFF_AD1:  rdata = adr_q[15:8];
        OFF_AD2:  rdata = adr_q[23:16];
        default:  rdata = 8'h00;
      endcase
    end
  end

  assign manual = (mode_q == 2'b00);
  assign count  = cnt_q;
  assign cfg    = '{asz: asz_q, dummy: dmy_q, cs_sel: sel_q, opcode: op_q,
                    dir: dir_q, addr: adr_q};

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int NUM_CS    = 2,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_cfg_t         cfg,
  input  logic [CNT_W-1:0]  count,
  input  logic [7:0]        buf_rdata,
  output logic [IDX_W-1:0]  buf_ridx,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_widx,
  output logic [7:0]        buf_wdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);

  phase_t           ph_q, ph_d, nxt, after_opc, after_adr, after_dmy;
  logic             hi_q, hi_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [4:0]       dc_q, dc_d;
  logic [7:0]       rx_q, rx_d;
  logic [1:0]       asz_eff;
  logic             adv;
  logic             active;
  logic [7:0]       adr_byte;

  always_comb begin
    asz_eff   = (cfg.asz > 3'd3) ? 2'd3 : cfg.asz[1:0];
    after_dmy = (count != '0) ? PH_DATA : PH_HOLD;
    after_adr = (cfg.dummy != 5'd0) ? PH_DUMMY : after_dmy;
    after_opc = (asz_eff != 2'd0) ? PH_ADDR : after_adr;
  end

  always_comb begin
    ph_d   = ph_q;
    hi_d   = hi_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    dc_d   = dc_q;
    rx_d   = rx_q;
    buf_we = 1'b0;
    adv    = 1'b0;
    nxt    = PH_IDLE;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_OPC;
          hi_d  = 1'b0;
          bit_d = 3'd0;
        end
      end
      PH_HOLD: begin
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd1) ph_d = PH_IDLE;
      end
      default: begin
        if (!hi_q) begin
          hi_d = 1'b1;
          if (ph_q == PH_DATA && !cfg.dir) rx_d = {rx_q[6:0], miso};
        end else begin
          hi_d  = 1'b0;
          bit_d = bit_q + 3'd1;
          unique case (ph_q)
            PH_OPC: begin
              if (bit_q == 3'd7) begin
                adv = 1'b1;
                nxt = after_opc;
              end
            end
            PH_ADDR: begin
              if (bit_q == 3'd7) begin
                if (byte_q == '0) begin
                  adv = 1'b1;
                  nxt = after_adr;
                end else begin
                  byte_d = byte_q - CNT_W'(1);
                end
              end
            end
            PH_DUMMY: begin
              dc_d = dc_q + 5'd1;
              if (dc_q == cfg.dummy - 5'd1) begin
                adv = 1'b1;
                nxt = after_dmy;
              end
            end
            PH_DATA: begin
              if (bit_q == 3'd7) begin
                buf_we = ~cfg.dir;
                if (byte_q == count - CNT_W'(1)) begin
                  adv = 1'b1;
                  nxt = PH_HOLD;
                end else begin
                  byte_d = byte_q + CNT_W'(1);
                end
              end
            end
            default: ;
          endcase
        end
      end
    endcase
    if (adv) begin
      ph_d   = nxt;
      bit_d  = 3'd0;
      dc_d   = 5'd0;
      byte_d = (nxt == PH_ADDR) ? CNT_W'(asz_eff) - CNT_W'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      hi_q   <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      dc_q   <= '0;
      rx_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      hi_q   <= hi_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      dc_q   <= dc_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    unique case (byte_q[1:0])
      2'd0:    adr_byte = cfg.addr[7:0];
      2'd1:    adr_byte = cfg.addr[15:8];
      default: adr_byte = cfg.addr[23:16];
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_OPC:  mosi = cfg.opcode[~bit_q];
      PH_ADDR: mosi = adr_byte[~bit_q];
      PH_DATA: mosi = cfg.dir & buf_rdata[~bit_q];
      default: mosi = 1'b0;
    endcase
  end

  assign active    = (ph_q != PH_IDLE) && (ph_q != PH_HOLD);
  assign busy      = (ph_q != PH_IDLE);
  assign sclk      = hi_q;
  assign buf_ridx  = byte_q[IDX_W-1:0];
  assign buf_widx  = byte_q[IDX_W-1:0];
  assign buf_wdata = rx_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(active && (32'(cfg.cs_sel) == g));
  end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int NUM_CS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int IDX_W = $clog2(BUF_BYTES);

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic             start;
  logic             manual;
  logic             busy;
  xfer_cfg_t        cfg;
  logic [CNT_W-1:0] count;
  logic [IDX_W-1:0] buf_ridx, buf_widx;
  logic [7:0]       buf_rdata, buf_wdata;
  logic             buf_we;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  spi_seq_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .start     (start),
    .manual    (manual),
    .cfg       (cfg),
    .count     (count),
    .buf_ridx  (buf_ridx),
    .buf_rdata (buf_rdata),
    .eng_we    (buf_we),
    .eng_widx  (buf_widx),
    .eng_wdata (buf_wdata)
  );

  spi_seq_engine #(.BUF_BYTES(BUF_BYTES), .NUM_CS(NUM_CS)) u_engine (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .cfg       (cfg),
    .count     (count),
    .buf_rdata (buf_rdata),
    .buf_ridx  (buf_ridx),
    .buf_we    (buf_we),
    .buf_widx  (buf_widx),
    .buf_wdata (buf_wdata),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .cs_n      (spi_cs_n),
    .busy      (busy)
  );

endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              start_bit,
  input logic              manual,
  input logic              busy,
  input logic              spi_sclk,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);

  assert_single_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  assert_cs_leads_sclk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> ($past(spi_cs_n) != '1));

  assert_select_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != '1 && $past(spi_cs_n) != '1) |-> $stable(spi_cs_n));

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (spi_cs_n == '1 && $past(spi_cs_n) == '1 && $past(spi_cs_n, 2) == '1));

  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n == '1) |-> (!spi_sclk && !spi_mosi));

  assert_busy_covers_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n != '1) |-> busy);

  assert_auto_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && start_bit && !manual && !busy) |=> !busy);

endmodule

bind spi_flash_seq spi_flash_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .ctl_wr    (reg_we && reg_addr == 7'h04),
  .start_bit (reg_wdata[0]),
  .manual    (manual),
  .busy      (busy),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_cs_n  (spi_cs_n)
);

// File: tb/test_spi_flash_seq.sv
module test_spi_flash_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_sclk, spi_mosi, spi_miso;
  logic [1:0] spi_cs_n;

  int  total = 0;
  int  fails = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  spi_flash_seq i_spi_flash_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // vector: opcode, asz, dummy, dir, count, addr, seed, cs
  localparam logic [56:0] VEC [0:7] = '{
    {8'h0B, 3'd3, 5'd8,  1'b0, 7'd16, 24'h123456, 8'h3C, 1'b0},
    {8'h02, 3'd3, 5'd0,  1'b1, 7'd64, 24'hABCDEF, 8'h11, 1'b1},
    {8'h03, 3'd3, 5'd0,  1'b0, 7'd64, 24'h000100, 8'h77, 1'b0},
    {8'hE9, 3'd0, 5'd0,  1'b1, 7'd0,  24'h000000, 8'h00, 1'b0},
    {8'h06, 3'd0, 5'd0,  1'b1, 7'd0,  24'h000000, 8'h00, 1'b1},
    {8'h9F, 3'd0, 5'd0,  1'b0, 7'd3,  24'h000000, 8'hC2, 1'b1},
    {8'h05, 3'd1, 5'd3,  1'b0, 7'd1,  24'h00005A, 8'h80, 1'b0},
    {8'h32, 3'd3, 5'd31, 1'b1, 7'd1,  24'hFFFFFF, 8'hFE, 1'b1}
  };

  function automatic logic [7:0] wbyte(logic [7:0] seed, int j);
    return seed + 8'(j * 5);
  endfunction

  function automatic logic [7:0] rbyte(logic [7:0] seed, int j);
    return seed ^ 8'(j * 29);
  endfunction

  // flash model: records MOSI on rising SCLK, supplies MISO by rise index
  int         rc = 0;
  int         d0 = 0;
  logic [7:0] rseed = '0;
  logic       cap [0:1023];
  logic [1:0] cs_seen = 2'b11;

  function automatic logic miso_of(int k, int base, logic [7:0] seed);
    logic [7:0] b;
    if (k < base) return 1'b0;
    b = rbyte(seed, (k - base) / 8);
    return b[7 - ((k - base) % 8)];
  endfunction

  assign spi_miso = miso_of(rc, d0, rseed);

  always @(negedge (&spi_cs_n)) begin
    rc = 0;
    cs_seen = spi_cs_n;
  end

  always @(posedge spi_sclk) begin
    if (rc < 1024) cap[rc] = spi_mosi;
    rc = rc + 1;
  end

  function automatic logic exp_bit(logic [56:0] v, int k);
    logic [7:0]  op   = v[56:49];
    int          asz  = int'(v[48:46]);
    int          dmy  = int'(v[45:41]);
    logic        dir  = v[40];
    logic [23:0] ad   = v[32:9];
    logic [7:0]  sd   = v[8:1];
    logic [7:0]  b;
    if (k < 8) return op[7 - k];
    k -= 8;
    if (k < 8 * asz) return ad[8 * asz - 1 - k];
    k -= 8 * asz;
    if (k < dmy) return 1'b0;
    k -= dmy;
    if (!dir) return 1'b0;
    b = wbyte(sd, k / 8);
    return b[7 - (k % 8)];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_vec(logic [56:0] v, bit poke);
    logic [7:0]  op   = v[56:49];
    logic [2:0]  asz  = v[48:46];
    logic [4:0]  dmy  = v[45:41];
    logic        dir  = v[40];
    logic [6:0]  cnt  = v[39:33];
    logic [23:0] ad   = v[32:9];
    logic [7:0]  sd   = v[8:1];
    logic        cs   = v[0];
    int          nbits, n, bad;
    logic [7:0]  r;
    nbits = 8 + 8 * int'(asz) + int'(dmy) + 8 * int'(cnt);
    d0    = 8 + 8 * int'(asz) + int'(dmy);
    rseed = sd;
    @(negedge clk);
    wr(7'h02, {dmy, asz});
    wr(7'h03, {7'b0, cs});
    wr(7'h05, op);
    wr(7'h08, ad[7:0]);
    wr(7'h09, ad[15:8]);
    wr(7'h0A, ad[23:16]);
    wr(7'h06, {1'b0, cnt});
    if (dir) for (int j = 0; j < int'(cnt); j++) wr(7'h40 + 7'(j), wbyte(sd, j));
    wr(7'h04, {4'b0000, dir, 3'b001});
    n = 0;
    if (poke) begin
      wr(7'h05, 8'hFF);        n++;
      wr(7'h06, 8'h02);        n++;
      wr(7'h08, 8'h00);        n++;
      wr(7'h02, 8'hFF);        n++;
      wr(7'h40, ~wbyte(sd, 0)); n++;
      wr(7'h04, 8'h30);        n++;
      wr(7'h03, {7'b0, ~cs});  n++;
    end
    while (i_spi_flash_seq.reg_rdata !== 8'hxx && n < 5000) begin
      reg_addr = 7'h04;
      #1;
      if (reg_rdata[1] == 1'b0) break;
      n++;
      @(negedge clk);
    end
    check("R3 busy length", 32'(n), 32'(2 * nbits + 2));
    check("R4 SCLK count", 32'(rc), 32'(nbits));
    bad = 0;
    for (int k = 0; k < nbits && k < 1024; k++) if (cap[k] !== exp_bit(v, k)) bad++;
    check(dir ? "R4/R5/R6/R7 MOSI stream write" : "R4/R5/R6/R7 MOSI stream read", 32'(bad), 0);
    check("R9 chip select used", 32'(cs_seen), cs ? 32'h1 : 32'h2);
    rd(7'h04, r);
    check("R3 control after done", 32'(r), 32'({4'b0000, dir, 3'b000}));
    rd(7'h02, r); check("R10 config readback", 32'(r), 32'({dmy, asz}));
    rd(7'h03, r); check("R10 select readback", 32'(r), 32'(cs));
    rd(7'h05, r); check("R10 opcode readback", 32'(r), 32'(op));
    rd(7'h06, r); check("R10 count readback", 32'(r), 32'(cnt));
    rd(7'h08, r); check("R11 address byte 0", 32'(r), 32'(ad[7:0]));
    rd(7'h09, r); check("R11 address byte 1", 32'(r), 32'(ad[15:8]));
    rd(7'h0A, r); check("R11 address byte 2", 32'(r), 32'(ad[23:16]));
    if (!dir && cnt != 0) begin
      bad = 0;
      for (int j = 0; j < int'(cnt); j++) begin
        rd(7'h40 + 7'(j), r);
        if (r !== rbyte(sd, j)) bad++;
      end
      check("R7 read data in buffer", 32'(bad), 0);
    end
    if (dir && poke) begin
      rd(7'h40, r);
      check("R10 buffer write while busy", 32'(r), 32'(wbyte(sd, 0)));
    end
  endtask

  initial begin
    logic [7:0] r;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(7'h04, r); check("R1 control reset", 32'(r), 32'h30);
    rd(7'h06, r); check("R1 count reset", 32'(r), 32'h00);
    check("R1 cs idle", 32'(spi_cs_n), 32'h3);
    check("R1 sclk/mosi idle", 32'({spi_sclk, spi_mosi}), 32'h0);

    // start and mode clear without unlock
    @(negedge clk);
    wr(7'h04, 8'h01);
    repeat (3) @(negedge clk);
    check("R2 no start in auto mode", 32'(spi_cs_n), 32'h3);
    rd(7'h04, r); check("R2 mode kept without unlock", 32'(r), 32'h30);

    // broken unlock pattern
    @(negedge clk);
    wr(7'h05, 8'h55); wr(7'h05, 8'h12); wr(7'h05, 8'hAA); wr(7'h04, 8'h00);
    rd(7'h04, r); check("R2 broken unlock", 32'(r), 32'h30);

    // proper unlock
    @(negedge clk);
    wr(7'h05, 8'h55); wr(7'h05, 8'hAA); wr(7'h04, 8'h00);
    rd(7'h04, r); check("R2 unlocked manual", 32'(r), 32'h00);

    @(negedge clk);
    wr(7'h06, 8'd100);
    rd(7'h06, r); check("R8 count clamp", 32'(r), 32'd64);

    for (int i = 0; i < 8; i++) run_vec(VEC[i], 1'b0);
    run_vec(VEC[1], 1'b1);

    // back to automatic mode; start refused again
    @(negedge clk);
    wr(7'h04, 8'h30); wr(7'h04, 8'h01);
    repeat (3) @(negedge clk);
    check("R2 start refused after return to auto", 32'(spi_cs_n), 32'h3);
    rd(7'h04, r); check("R2 auto mode restored", 32'(r), 32'h30);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule